// File: doc/BRIEF.md
# Index-Next-Instruction Fetch Modifier

This block sits on the path from instruction fetch to the instruction register (IR) of a small accumulator machine. Normally a fetched instruction word is loaded into the IR unchanged. When the execute stage reports that an indexing instruction has run, the block arms a pending flag. The next fetched word is then loaded into the IR as the sum of that word and the current accumulator, modulo 2^W. The flag drops at that load, so exactly one following instruction is altered.

Program memory is never written. The change exists only in the IR, so the block behaves the same whether the program sits in read-only or writable memory. Decode and execution are outside the block. The adder can be built as a plain behavioural sum or as an explicit ripple chain, chosen by a parameter.

Top module: `index_fetch_modifier`

## Requirements
- R1: With `rst` high at a rising edge, the IR becomes 0 and the pending flag clears. A pulse on `index_exec` given before that reset therefore does not affect the first fetch after it.
- R2: With no pending flag, a rising edge with `fetch_valid` high loads `fetch_word` unchanged into `ir`. The new value shows after that edge.
- R3: With the pending flag set, a rising edge with `fetch_valid` high loads `(fetch_word + acc) mod 2^W` into `ir`. Any carry out of the top bit is dropped. With W=16, 0xFFFF + 0x0002 gives 0x0001.
- R4: The pending flag clears on the load it modifies. The fetch after that is loaded unchanged.
- R5: On an edge with `fetch_valid` low, `ir` holds its value and the pending flag is kept. The next valid fetch is still modified.
- R6: A pulse on `index_exec` while the modified instruction is in the IR arms the flag again. It then applies to the next fetch.
- R7: Only the `acc` value present in the same cycle as the valid fetch enters the sum. Values of `acc` in other cycles have no effect.
- R8: If `index_exec` and `fetch_valid` are both high at the same edge, that fetch is loaded according to the flag as it stood before the edge. The flag is then set for the following fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetched word is present this cycle |
| fetch_word | input | W (16) | Instruction word from program memory |
| acc | input | W (16) | Accumulator value |
| index_exec | input | 1 | One-cycle pulse: an indexing instruction executed |
| ir | output | W (16) | Instruction register contents |

## Verification
Every result is due on the first rising edge after the stimulus, because `ir` and the pending flag are single registers. The bench drives inputs on the falling edge and reads `ir` one time unit after the next rising edge. The flag has no port, so its state is observed through what the next valid fetch loads. Checks therefore pair the stimulus cycle with the fetch that follows it, and idle cycles between them check R5 and R7.

// File: rtl/idx_fetch_pkg.sv
package idx_fetch_pkg;

   // Adder build variants
   localparam int ADD_BEHAVIOURAL = 0;
   localparam int ADD_RIPPLE      = 1;

   // What the IR takes on a valid fetch
   typedef enum logic {
      LOAD_PLAIN   = 1'b0,
      LOAD_INDEXED = 1'b1
   } load_sel_e;

endpackage

// File: rtl/idx_pending_tracker.sv
module idx_pending_tracker
   import idx_fetch_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      fetch_valid,
   input  logic      index_exec,
   output logic      pend,
   output load_sel_e load_sel
);

   logic pend_q;
   logic pend_d;

   // A new arm wins over the clear from this cycle's load
   always_comb begin
      pend_d = pend_q;
      if (fetch_valid) begin
         pend_d = 1'b0;
      end
      if (index_exec) begin
         pend_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
      end
   end

   assign pend     = pend_q;
   assign load_sel = pend_q ? LOAD_INDEXED : LOAD_PLAIN;

endmodule

// File: rtl/idx_word_adder.sv
module idx_word_adder
   import idx_fetch_pkg::*;
#(
   parameter int W     = 16,
   parameter int STYLE = ADD_BEHAVIOURAL
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);

   generate
      if (STYLE != ADD_BEHAVIOURAL && STYLE != ADD_RIPPLE) begin : g_bad_style
         $error("idx_word_adder: unknown STYLE");
      end

      if (STYLE == ADD_RIPPLE) begin : g_ripple
         if (W == 1) begin : g_one
            assign sum = a ^ b;
         end else begin : g_chain
            logic [W-1:0] cy;
            assign cy[0] = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_bit
               assign sum[i] = a[i] ^ b[i] ^ cy[i];
               if (i < W - 1) begin : g_carry
                  assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
               end
            end
         end
      end else begin : g_behav
         assign sum = a + b;
      end
   endgenerate

endmodule

// File: rtl/idx_ir_register.sv
module idx_ir_register
   import idx_fetch_pkg::*;
#(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         fetch_valid,
   input  load_sel_e    load_sel,
   input  logic [W-1:0] plain_word,
   input  logic [W-1:0] indexed_word,
   output logic [W-1:0] ir_q
);

   logic [W-1:0] next_word;

   always_comb begin
      unique case (load_sel)
         LOAD_INDEXED: next_word = indexed_word;
         default:      next_word = plain_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q <= '0;
      end else if (fetch_valid) begin
         ir_q <= next_word;
      end
   end

endmodule

// File: rtl/index_fetch_modifier.sv
module index_fetch_modifier
   import idx_fetch_pkg::*;
#(
   parameter int W         = 16,
   parameter int ADD_STYLE = ADD_BEHAVIOURAL
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         fetch_valid,
   input  logic [W-1:0] fetch_word,
   input  logic [W-1:0] acc,
   input  logic         index_exec,
   output logic [W-1:0] ir
);

   generate
      if (W < 1) begin : g_bad_width
         $error("index_fetch_modifier: W must be at least 1");
      end
   endgenerate

   logic         pend;
   load_sel_e    load_sel;
   logic [W-1:0] sum_word;

   idx_pending_tracker u_pend (
      .clk         (clk),
      .rst         (rst),
      .fetch_valid (fetch_valid),
      .index_exec  (index_exec),
      .pend        (pend),
      .load_sel    (load_sel)
   );

   idx_word_adder #(.W(W), .STYLE(ADD_STYLE)) u_add (
      .a   (fetch_word),
      .b   (acc),
      .sum (sum_word)
   );

   idx_ir_register #(.W(W)) u_ir (
      .clk          (clk),
      .rst          (rst),
      .fetch_valid  (fetch_valid),
      .load_sel     (load_sel),
      .plain_word   (fetch_word),
      .indexed_word (sum_word),
      .ir_q         (ir)
   );

endmodule

// File: rtl/idx_fetch_checker.sv
module idx_fetch_checker #(
   parameter int W = 16
)(
   input logic         clk,
   input logic         rst,
   input logic         fetch_valid,
   input logic [W-1:0] fetch_word,
   input logic [W-1:0] acc,
   input logic         index_exec,
   input logic         pend,
   input logic [W-1:0] ir
);

   // Independent shadow of the armed state, written from the requirements
   logic armed;
   always_ff @(posedge clk) begin
      if (rst)             armed <= 1'b0;
      else if (index_exec) armed <= 1'b1;
      else if (fetch_valid) armed <= 1'b0;
   end

   // R1: the edge after reset leaves IR at zero
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (ir == '0 && !pend));

   // R2: unarmed fetch loads the word unchanged
   p_plain_load_r2: assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && !armed) |=> ir == $past(fetch_word));

   // R3 / R7: armed fetch loads word plus same-cycle accumulator
   p_indexed_load_r3: assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && armed) |=> ir == W'($past(fetch_word) + $past(acc)));

   // R4: a modifying load without a new arm leaves the flag clear
   p_single_use_r4: assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && !index_exec) |=> !pend);

   // R5: idle edges hold the IR
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!fetch_valid) |=> $stable(ir));

   // R6 / R8: an arm pulse always leaves the flag set
   p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
      index_exec |=> pend);

endmodule

bind index_fetch_modifier idx_fetch_checker #(.W(W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fetch_valid (fetch_valid),
   .fetch_word  (fetch_word),
   .acc         (acc),
   .index_exec  (index_exec),
   .pend        (pend),
   .ir          (ir)
);

// File: tb/tb_index_fetch_modifier.sv
module tb_index_fetch_modifier;

   localparam int W          = 16;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         fetch_valid;
   logic [W-1:0] fetch_word;
   logic [W-1:0] acc;
   logic         index_exec;
   logic [W-1:0] ir;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   index_fetch_modifier #(.W(W)) dut (
      .clk         (clk),
      .rst         (rst),
      .fetch_valid (fetch_valid),
      .fetch_word  (fetch_word),
      .acc         (acc),
      .index_exec  (index_exec),
      .ir          (ir)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // One clock: drive on falling edge, sample just after rising edge
   task automatic step(input logic r, input logic v, input logic [W-1:0] w,
                       input logic [W-1:0] a, input logic x);
      @(negedge clk);
      rst = r; fetch_valid = v; fetch_word = w; acc = a; index_exec = x;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_ir(input string req, input logic [W-1:0] exp);
      checks++;
      if (ir !== exp) begin
         errors++;
         $display("FAIL %s ir=%h expected=%h", req, ir, exp);
      end
   endtask

   task automatic arm();
      step(1'b0, 1'b0, 16'hDEAD, 16'hBEEF, 1'b1);
   endtask

   task automatic t_reset();
      step(1'b1, 1'b0, '0, '0, 1'b0);
      step(1'b1, 1'b0, '0, '0, 1'b0);
      expect_ir("R1", 16'h0000);
      step(1'b0, 1'b1, 16'h1111, 16'h0000, 1'b0);
      arm();
      step(1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0);
      expect_ir("R1", 16'h0000);
      step(1'b0, 1'b1, 16'h2222, 16'h0100, 1'b0);
      expect_ir("R1", 16'h2222);
   endtask

   task automatic t_plain();
      step(1'b0, 1'b1, 16'hA5A5, 16'h1234, 1'b0);
      expect_ir("R2", 16'hA5A5);
      step(1'b0, 1'b1, 16'h0F0F, 16'hFFFF, 1'b0);
      expect_ir("R2", 16'h0F0F);
   endtask

   task automatic t_sum();
      arm();
      step(1'b0, 1'b1, 16'h1234, 16'h0101, 1'b0);
      expect_ir("R3", 16'h1335);
      arm();
      step(1'b0, 1'b1, 16'hFFFF, 16'h0002, 1'b0);
      expect_ir("R3", 16'h0001);
   endtask

   task automatic t_single();
      arm();
      step(1'b0, 1'b1, 16'h0100, 16'h0020, 1'b0);
      expect_ir("R4", 16'h0120);
      step(1'b0, 1'b1, 16'h0300, 16'h0020, 1'b0);
      expect_ir("R4", 16'h0300);
   endtask

   task automatic t_idle();
      step(1'b0, 1'b1, 16'h4444, 16'h0000, 1'b0);
      arm();
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0, 16'h9999, 16'h7777, 1'b0);
         expect_ir("R5", 16'h4444);
      end
      step(1'b0, 1'b1, 16'h5000, 16'h0005, 1'b0);
      expect_ir("R5", 16'h5005);
   endtask

   task automatic t_chain();
      arm();
      step(1'b0, 1'b1, 16'h6000, 16'h0006, 1'b0);
      expect_ir("R6", 16'h6006);
      step(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1);
      step(1'b0, 1'b1, 16'h6100, 16'h0011, 1'b0);
      expect_ir("R6", 16'h6111);
   endtask

   task automatic t_acc_sample();
      arm();
      step(1'b0, 1'b0, 16'h0000, 16'h5555, 1'b0);
      step(1'b0, 1'b1, 16'h7000, 16'h0010, 1'b0);
      expect_ir("R7", 16'h7010);
   endtask

   task automatic t_coincide();
      step(1'b0, 1'b1, 16'h8000, 16'h0008, 1'b1);
      expect_ir("R8", 16'h8000);
      step(1'b0, 1'b1, 16'h8100, 16'h0008, 1'b0);
      expect_ir("R8", 16'h8108);
   endtask

   initial begin
      rst = 1'b1; fetch_valid = 1'b0; fetch_word = '0; acc = '0; index_exec = 1'b0;
      t_reset();
      t_plain();
      t_sum();
      t_single();
      t_idle();
      t_chain();
      t_acc_sample();
      t_coincide();
      step(1'b0, 1'b0, '0, '0, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule